// File: doc/BRIEF.md
# Linked Command Block Sequencer

This block is the command-unit controller for a list of command blocks kept in shared memory. Software hands it a block address with a start request, or continues a paused list with a resume request. For each block it waits until the receive side stops stalling. It then reads the header words in one back-to-back burst over a simple 32-bit word port and decodes the command word. It pulses a start strobe to an external action executor, which receives the 3-bit command code, the block address and the first optional argument word.

While the executor works, the sequencer reads the next block's command word at the saved link address and keeps its control flags as a hint. When the executor reports completion, the sequencer does a read-modify-write of the block's first word. This sets the complete flag, records the executor's OK flag and status code, and leaves the command half untouched. The three control flags of the finished block then decide what happens next: an interrupt request is raised if asked for, and the unit goes idle, pauses, or moves on to the next block. For a transmit action, the executor reports completion once the last buffer copy is done, so buffer memory is returned early.

Block word 0 layout: bit 31 end-of-list, bit 30 suspend, bit 29 interrupt, bits 28:19 reserved zero, bits 18:16 command code, bit 15 complete, bit 14 reserved (preserved), bit 13 OK, bits 12:0 status code. Word 1 holds the byte address of the next block, word 2 the argument.

Top module: `cbl_sequencer`

## Requirements
- R1: After reset `cu_state` is 0 (idle), `irq_cx`, `act_start` and `mem_req` are low; no memory access is made while idle.
- R2: An accepted request reads the block's four words at byte addresses A, A+4, A+8, A+12 on consecutive acknowledged cycles; `act_arg` then holds the word at A+8.
- R3: While `rx_stall` is high before a block's burst begins, no memory request is made and `cu_state` stays 1 (active).
- R4: `act_start` is high for exactly one cycle per block, with `act_cmd` equal to bits 18:16 of word 0 and `act_addr` equal to the block address.
- R5: When end-of-list is clear, the word at the link address is read before completion is processed, and `pf_valid` rises with `pf_hint` = {bit 31, bit 30, bit 29, bits 18:16} of that word.
- R6: On completion word 0 becomes {old bits 31:16, 1, old bit 14, `act_ok`, `act_stat`}.
- R7: If the interrupt flag of a completed block is set, `irq_cx` rises and stays high until a one-cycle `irq_ack` clears it.
- R8: A completed block with end-of-list set returns the unit to idle (state 0), whatever the suspend flag.
- R9: With end-of-list clear and suspend set, the unit enters state 2 (suspended); a resume request then runs the block at the saved link address.
- R10: With both end-of-list and suspend clear, the unit fetches the block at the link address without any new request.
- R11: A start request is ignored while active, and a resume request is ignored unless suspended; a start request is accepted in idle or suspended.
- R12: `cu_state` only takes the encodings 0 (idle), 1 (active) and 2 (suspended).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Start the list at `start_addr` |
| start_addr | input | ADDR_W | Byte address of the first block |
| resume_req | input | 1 | Continue a suspended list |
| rx_stall | input | 1 | Receive activity; holds off a block fetch |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes this cycle |
| act_start | output | 1 | One-cycle launch strobe to the executor |
| act_cmd | output | 3 | Command code of the current block |
| act_addr | output | ADDR_W | Address of the current block |
| act_arg | output | 32 | Word at block offset 8 |
| act_done | input | 1 | Executor finished (from the cycle after launch) |
| act_ok | input | 1 | Executor result flag, with `act_done` |
| act_stat | input | 13 | Executor status code, with `act_done` |
| pf_valid | output | 1 | Prefetched next-block flags are valid |
| pf_hint | output | 6 | Prefetched {end, suspend, interrupt, code} |
| irq_cx | output | 1 | Completion interrupt request |
| irq_ack | input | 1 | Clears `irq_cx` |
| cu_state | output | 2 | 0 idle, 1 active, 2 suspended |

## Verification
On every cycle the assertions check several properties: the state encoding stays legal; no bus access is made while idle; the launch strobe lasts one cycle; the interrupt request is sticky and clears on acknowledge; and the active, suspended and idle states are only left through a status write or an accepted request. The bench scenarios cover everything that depends on data and ordering: burst addresses, the prefetch address and hint, the merged status word with the preserved bits, the choice between idle, suspend and chaining, the stall hold-off, and requests that must be ignored.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int STAT_W = 13;
    localparam int CMD_W  = 3;

    typedef enum logic [1:0] {
        CU_IDLE   = 2'd0,
        CU_ACTIVE = 2'd1,
        CU_SUSP   = 2'd2
    } cu_state_e;

    typedef enum logic [2:0] {
        PH_HALT,
        PH_GATE,
        PH_BURST,
        PH_LAUNCH,
        PH_PREF,
        PH_EXEC,
        PH_WBRD,
        PH_WBWR
    } phase_e;

    typedef struct packed {
        logic             last;
        logic             pause;
        logic             intr;
        logic [CMD_W-1:0] code;
    } ctl_t;
endpackage

// File: rtl/cbl_hdr_decode.sv
module cbl_hdr_decode
    import cbl_pkg::*;
(
    input  logic [2:0]       flag_bits,
    input  logic [CMD_W-1:0] code_bits,
    output ctl_t             ctl
);
    always_comb begin
        ctl.last  = flag_bits[2];
        ctl.pause = flag_bits[1];
        ctl.intr  = flag_bits[0];
        ctl.code  = code_bits;
    end
endmodule

// File: rtl/cbl_status_merge.sv
module cbl_status_merge
    import cbl_pkg::*;
(
    input  logic [HALF_W-1:0] keep_hi,
    input  logic              keep_x,
    input  logic              ok,
    input  logic [STAT_W-1:0] stat,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        word = {keep_hi, 1'b1, keep_x, ok, stat};
    end
endmodule

// File: rtl/cbl_irq_latch.sv
module cbl_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    output logic irq
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (ack)
            irq_d = 1'b0;
        if (set)
            irq_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= irq_d;
    end

    assign irq = irq_q;
endmodule

// File: rtl/cbl_sequencer.sv
module cbl_sequencer
    import cbl_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              resume_req,
    input  logic              rx_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              act_start,
    output logic [CMD_W-1:0]  act_cmd,
    output logic [ADDR_W-1:0] act_addr,
    output logic [WORD_W-1:0] act_arg,
    input  logic              act_done,
    input  logic              act_ok,
    input  logic [STAT_W-1:0] act_stat,
    output logic              pf_valid,
    output logic [CMD_W+2:0]  pf_hint,
    output logic              irq_cx,
    input  logic              irq_ack,
    output logic [1:0]        cu_state
);
    localparam int BEAT_W     = $clog2(BURST_LEN);
    localparam int BYTE_SHIFT = $clog2(WORD_W / 8);
    localparam logic [BEAT_W-1:0] BEAT_HDR  = BEAT_W'(0);
    localparam logic [BEAT_W-1:0] BEAT_LINK = BEAT_W'(1);
    localparam logic [BEAT_W-1:0] BEAT_ARG  = BEAT_W'(2);
    localparam logic [BEAT_W-1:0] BEAT_END  = BEAT_W'(BURST_LEN - 1);

    typedef struct packed {
        phase_e             phase;
        cu_state_e          cu;
        logic [ADDR_W-1:0]  blk_addr;
        logic [ADDR_W-1:0]  link_addr;
        logic [BEAT_W-1:0]  beat;
        ctl_t               cur;
        logic [WORD_W-1:0]  arg;
        ctl_t               pf;
        logic               pf_vld;
        logic               done_seen;
        logic               ok;
        logic [STAT_W-1:0]  stat;
        logic [HALF_W-1:0]  keep_hi;
        logic               keep_x;
    } seq_t;

    seq_t seq_d, seq_q;

    ctl_t              hdr_ctl;
    logic [WORD_W-1:0] merged_word;
    logic              irq_set;
    logic              req_c, we_c, launch_c;
    logic [ADDR_W-1:0] addr_c;

    cbl_hdr_decode u_decode (
        .flag_bits (mem_rdata[WORD_W-1:WORD_W-3]),
        .code_bits (mem_rdata[HALF_W+CMD_W-1:HALF_W]),
        .ctl       (hdr_ctl)
    );

    cbl_status_merge u_merge (
        .keep_hi (seq_q.keep_hi),
        .keep_x  (seq_q.keep_x),
        .ok      (seq_q.ok),
        .stat    (seq_q.stat),
        .word    (merged_word)
    );

    cbl_irq_latch u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_set),
        .ack   (irq_ack),
        .irq   (irq_cx)
    );

    always_comb begin
        seq_d    = seq_q;
        req_c    = 1'b0;
        we_c     = 1'b0;
        launch_c = 1'b0;
        addr_c   = seq_q.blk_addr;
        irq_set  = 1'b0;

        // capture the executor result while waiting for it
        if ((seq_q.phase == PH_PREF || seq_q.phase == PH_EXEC) && act_done) begin
            seq_d.done_seen = 1'b1;
            seq_d.ok        = act_ok;
            seq_d.stat      = act_stat;
        end

        case (seq_q.phase)
            PH_HALT: begin
                if (start_req) begin
                    seq_d.blk_addr = start_addr;
                    seq_d.phase    = PH_GATE;
                    seq_d.cu       = CU_ACTIVE;
                end else if (resume_req && seq_q.cu == CU_SUSP) begin
                    seq_d.blk_addr = seq_q.link_addr;
                    seq_d.phase    = PH_GATE;
                    seq_d.cu       = CU_ACTIVE;
                end
            end
            PH_GATE: begin
                seq_d.pf_vld    = 1'b0;
                seq_d.done_seen = 1'b0;
                if (!rx_stall) begin
                    seq_d.phase = PH_BURST;
                    seq_d.beat  = '0;
                end
            end
            PH_BURST: begin
                req_c  = 1'b1;
                addr_c = seq_q.blk_addr + (ADDR_W'(seq_q.beat) << BYTE_SHIFT);
                if (mem_ack) begin
                    if (seq_q.beat == BEAT_HDR)
                        seq_d.cur = hdr_ctl;
                    if (seq_q.beat == BEAT_LINK)
                        seq_d.link_addr = mem_rdata[ADDR_W-1:0];
                    if (seq_q.beat == BEAT_ARG)
                        seq_d.arg = mem_rdata;
                    if (seq_q.beat == BEAT_END)
                        seq_d.phase = PH_LAUNCH;
                    else
                        seq_d.beat = seq_q.beat + BEAT_W'(1);
                end
            end
            PH_LAUNCH: begin
                launch_c    = 1'b1;
                seq_d.phase = seq_q.cur.last ? PH_EXEC : PH_PREF;
            end
            PH_PREF: begin
                req_c  = 1'b1;
                addr_c = seq_q.link_addr;
                if (mem_ack) begin
                    seq_d.pf     = hdr_ctl;
                    seq_d.pf_vld = 1'b1;
                    seq_d.phase  = PH_EXEC;
                end
            end
            PH_EXEC: begin
                if (seq_q.done_seen || act_done)
                    seq_d.phase = PH_WBRD;
            end
            PH_WBRD: begin
                req_c = 1'b1;
                if (mem_ack) begin
                    seq_d.keep_hi = mem_rdata[WORD_W-1:HALF_W];
                    seq_d.keep_x  = mem_rdata[HALF_W-2];
                    seq_d.phase   = PH_WBWR;
                end
            end
            PH_WBWR: begin
                req_c = 1'b1;
                we_c  = 1'b1;
                if (mem_ack) begin
                    irq_set = seq_q.cur.intr;
                    if (seq_q.cur.last) begin
                        seq_d.phase  = PH_HALT;
                        seq_d.cu     = CU_IDLE;
                        seq_d.pf_vld = 1'b0;
                    end else if (seq_q.cur.pause) begin
                        seq_d.phase = PH_HALT;
                        seq_d.cu    = CU_SUSP;
                    end else begin
                        seq_d.blk_addr = seq_q.link_addr;
                        seq_d.phase    = PH_GATE;
                    end
                end
            end
            default: seq_d.phase = PH_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            seq_q <= '0;
        else
            seq_q <= seq_d;
    end

    assign mem_req   = req_c;
    assign mem_we    = we_c;
    assign mem_addr  = addr_c;
    assign mem_wdata = merged_word;
    assign act_start = launch_c;
    assign act_cmd   = seq_q.cur.code;
    assign act_addr  = seq_q.blk_addr;
    assign act_arg   = seq_q.arg;
    assign pf_valid  = seq_q.pf_vld;
    assign pf_hint   = seq_q.pf;
    assign cu_state  = seq_q.cu;
endmodule

// File: rtl/cbl_sequencer_chk.sv
module cbl_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_req,
    input logic       resume_req,
    input logic       mem_req,
    input logic       mem_we,
    input logic       mem_ack,
    input logic       act_start,
    input logic       irq_cx,
    input logic       irq_ack,
    input logic [1:0] cu_state
);
    a_r1_idle_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        cu_state == 2'd0 |-> !mem_req);

    a_r4_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        act_start |=> !act_start);

    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cx && !irq_ack |=> irq_cx);

    a_r7_irq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack && !(mem_req && mem_we && mem_ack) |=> !irq_cx);

    a_r11_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cu_state == 2'd1 && !(mem_req && mem_we && mem_ack) |=> cu_state == 2'd1);

    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cu_state == 2'd0 && !start_req |=> cu_state == 2'd0);

    a_r9_susp_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cu_state == 2'd2 && !start_req && !resume_req |=> cu_state == 2'd2);

    a_r12_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        cu_state != 2'd3);
endmodule

bind cbl_sequencer cbl_sequencer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .resume_req (resume_req),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .act_start  (act_start),
    .irq_cx     (irq_cx),
    .irq_ack    (irq_ack),
    .cu_state   (cu_state)
);

// File: tb/cbl_sequencer_bench.sv
module cbl_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;
    localparam int LOG_N      = 512;
    localparam int NVEC       = 6;
    localparam logic [31:0] BLK_A  = 32'h10;
    localparam logic [31:0] BLK_B  = 32'h20;
    localparam logic [31:0] TERM_W = 32'h8007_0000;

    // vector: {last, pause, intr, code[2:0], ok, exp_state[1:0], exp_irq}
    localparam logic [9:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 3'd1, 1'b1, 2'd0, 1'b0},
        {1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 2'd0, 1'b1},
        {1'b0, 1'b1, 1'b0, 3'd3, 1'b1, 2'd2, 1'b0},
        {1'b0, 1'b0, 1'b1, 3'd4, 1'b1, 2'd0, 1'b1},
        {1'b1, 1'b1, 1'b0, 3'd5, 1'b1, 2'd0, 1'b0},
        {1'b0, 1'b1, 1'b1, 3'd6, 1'b0, 2'd2, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0;
    logic [31:0] start_addr = '0;
    logic        resume_req = 1'b0;
    logic        rx_stall = 1'b0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        act_start;
    logic [2:0]  act_cmd;
    logic [31:0] act_addr, act_arg;
    logic        act_done = 1'b0;
    logic        act_ok = 1'b0;
    logic [12:0] act_stat = '0;
    logic        pf_valid;
    logic [5:0]  pf_hint;
    logic        irq_cx;
    logic        irq_ack = 1'b0;
    logic [1:0]  cu_state;

    logic [31:0] mem [0:63];
    logic [31:0] rd_log [0:LOG_N-1];
    int rd_n = 0;
    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cbl_sequencer u_cbl_sequencer (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_addr(start_addr),
        .resume_req(resume_req), .rx_stall(rx_stall), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .act_start(act_start),
        .act_cmd(act_cmd), .act_addr(act_addr), .act_arg(act_arg),
        .act_done(act_done), .act_ok(act_ok), .act_stat(act_stat),
        .pf_valid(pf_valid), .pf_hint(pf_hint), .irq_cx(irq_cx),
        .irq_ack(irq_ack), .cu_state(cu_state)
    );

    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[7:2]];

    always @(negedge clk) begin
        if (mem_req && mem_we)
            mem[mem_addr[7:2]] = mem_wdata;
        if (mem_req && !mem_we) begin
            if (rd_n < LOG_N)
                rd_log[rd_n] = mem_addr;
            rd_n = rd_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_start(input logic [31:0] a);
        start_addr = a;
        start_req  = 1'b1;
        tick();
        start_req  = 1'b0;
    endtask

    task automatic do_resume();
        resume_req = 1'b1;
        tick();
        resume_req = 1'b0;
    endtask

    task automatic do_ack();
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
    endtask

    task automatic wait_launch();
        for (int k = 0; k < 200 && !act_start; k++)
            tick();
    endtask

    task automatic finish_exec(input logic ok, input logic [12:0] st);
        act_ok   = ok;
        act_stat = st;
        act_done = 1'b1;
        tick();
        act_done = 1'b0;
    endtask

    task automatic wait_settle();
        for (int k = 0; k < 200 && cu_state == 2'd1; k++)
            tick();
    endtask

    task automatic put_block(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] lnk,
                             input logic [31:0] arg);
        mem[a[7:2]]     = w0;
        mem[a[7:2] + 1] = lnk;
        mem[a[7:2] + 2] = arg;
        mem[a[7:2] + 3] = 32'h0;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", WD_CYCLES);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 64; k++)
            mem[k] = 32'h0;
        repeat (3) tick();
        // R1 reset state
        chk("R1 state", 32'(cu_state), 32'd0);
        chk("R1 irq", 32'(irq_cx), 32'd0);
        chk("R1 act_start", 32'(act_start), 32'd0);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        repeat (2) tick();
        chk("R1 idle no access", 32'(rd_n), 32'd0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            logic last, pause, intr, ok, xirq, chain;
            logic [2:0] code;
            logic [1:0] xst;
            logic [31:0] w0, after;
            logic [12:0] st;
            int base;
            {last, pause, intr, code, ok, xst, xirq} = VEC[v];
            chain = !last && !pause;
            w0 = {last, pause, intr, 10'b0, code, 16'h4000};
            st = 13'h0100 + 13'(v);
            put_block(BLK_A, w0, BLK_B, 32'hA500_0000 + 32'(v));
            put_block(BLK_B, TERM_W, 32'h0, 32'h0);
            if (irq_cx)
                do_ack();
            base = rd_n;
            do_start(BLK_A);
            wait_launch();
            chk("R4 cmd", 32'(act_cmd), 32'(code));
            chk("R4 addr", act_addr, BLK_A);
            chk("R2 arg", act_arg, 32'hA500_0000 + 32'(v));
            repeat (3) tick();
            if (!last) begin
                chk("R5 pf_valid", 32'(pf_valid), 32'd1);
                chk("R5 pf_hint", 32'(pf_hint), 32'h27);
                chk("R5 prefetch addr", rd_log[base + 4], BLK_B);
            end
            finish_exec(ok, st);
            if (chain) begin
                wait_launch();
                chk("R10 next cmd", 32'(act_cmd), 32'd7);
                chk("R10 next addr", act_addr, BLK_B);
                repeat (2) tick();
                finish_exec(1'b1, 13'h0);
            end
            wait_settle();
            for (int b = 0; b < 4; b++)
                chk("R2 burst addr", rd_log[base + b], BLK_A + 32'(4 * b));
            after = {w0[31:16], 1'b1, 1'b1, ok, st};
            chk("R6 status word", mem[BLK_A[7:2]], after);
            if (chain) begin
                chk("R10 chained burst", rd_log[base + 6], BLK_B);
                chk("R10 chained status", mem[BLK_B[7:2]], 32'h8007_A000);
            end
            chk(last ? "R8 end state" : (pause ? "R9 suspend state" : "R10 chain end state"),
                32'(cu_state), 32'(xst));
            chk("R7 irq", 32'(irq_cx), 32'(xirq));
        end

        // R3 stall holds off the fetch
        if (irq_cx)
            do_ack();
        put_block(BLK_A, 32'h8001_0000, BLK_B, 32'h0);
        rx_stall = 1'b1;
        begin
            int base;
            base = rd_n;
            do_start(BLK_A);
            repeat (6) tick();
            chk("R3 no access in stall", 32'(rd_n - base), 32'd0);
            chk("R3 active in stall", 32'(cu_state), 32'd1);
            rx_stall = 1'b0;
            wait_launch();
            repeat (2) tick();
            finish_exec(1'b1, 13'h0);
            wait_settle();
            chk("R3 fetch after stall", rd_log[base], BLK_A);
        end

        // R11 start while active is ignored, resume while idle is ignored
        put_block(BLK_A, 32'h8002_0000, BLK_B, 32'h0);
        begin
            int base;
            logic seen;
            base = rd_n;
            do_start(BLK_A);
            wait_launch();
            tick();
            do_start(32'h30);
            finish_exec(1'b1, 13'h0);
            wait_settle();
            seen = 1'b0;
            for (int k = base; k < rd_n; k++)
                if (rd_log[k] == 32'h30)
                    seen = 1'b1;
            chk("R11 start ignored when active", 32'(seen), 32'd0);
            chk("R11 idle after block", 32'(cu_state), 32'd0);
            base = rd_n;
            do_resume();
            repeat (4) tick();
            chk("R11 resume ignored in idle", 32'(rd_n - base), 32'd0);
            chk("R11 still idle", 32'(cu_state), 32'd0);
        end

        // R9 suspend then resume at the link address
        put_block(BLK_A, 32'h4003_0000, BLK_B, 32'h0);
        put_block(BLK_B, TERM_W, 32'h0, 32'h0);
        do_start(BLK_A);
        wait_launch();
        repeat (2) tick();
        finish_exec(1'b1, 13'h0);
        wait_settle();
        chk("R9 suspended", 32'(cu_state), 32'd2);
        begin
            int base;
            base = rd_n;
            do_resume();
            wait_launch();
            chk("R9 resumed cmd", 32'(act_cmd), 32'd7);
            chk("R9 resumed addr", act_addr, BLK_B);
            repeat (2) tick();
            finish_exec(1'b1, 13'h0);
            wait_settle();
            chk("R9 resume burst", rd_log[base], BLK_B);
            chk("R9 idle at end", 32'(cu_state), 32'd0);
        end

        // R7 interrupt stays until acknowledged
        if (irq_cx)
            do_ack();
        put_block(BLK_A, 32'hA001_0000, BLK_B, 32'h0);
        do_start(BLK_A);
        wait_launch();
        repeat (2) tick();
        finish_exec(1'b1, 13'h0);
        wait_settle();
        repeat (10) tick();
        chk("R7 irq held", 32'(irq_cx), 32'd1);
        do_ack();
        chk("R7 irq cleared", 32'(irq_cx), 32'd0);
        chk("R12 idle code", 32'(cu_state), 32'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule